// File: doc/BRIEF.md
# Serial Master Controller with Divided Bit Clock

This block is the master end of a four-wire synchronous serial link. Software reaches it through a small register port with three word addresses: a configuration word, a data window and a status word. Through the configuration word it picks the serial clock idle level and the sampling phase, a 3-bit rate code, the four active-low select lines and an enable bit. Software then writes bytes into an eight-entry transmit queue and reads captured bytes from an eight-entry receive queue.

While the block is enabled and the transmit queue holds data, it takes the oldest byte and shifts it out most significant bit first. At the same time it shifts a byte in from the slave and stores it in the receive queue. Queued bytes follow each other without a pause in the serial clock. The select lines are never driven by the shifter. They copy the software field, so software frames a transaction by writing the field before and after the bytes.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, csN is 4'b1111, sclk and mosi are 0, and the status word (address 2) reads 6'b000101 (both queues empty, no overflow, not busy).
- R2: With rate code n in configuration bits [5:3], sclk changes level every 2^n reference clock cycles during a transfer, so its period is 2^(n+1) reference cycles.
- R3: Each byte written to address 1 is sent on mosi most significant bit first. During the same byte, eight bits are captured from miso and queued, and reads of address 1 return the captured bytes in arrival order.
- R4: Configuration bit 0 sets the sclk idle level. With bit 1 clear, the first data bit is on mosi before the first sclk edge, miso is sampled on leading edges and mosi changes on trailing edges. With bit 1 set, mosi changes on leading edges and miso is sampled on trailing edges.
- R5: csN equals configuration bits [9:6] from the cycle after the write. 4'b1111 deselects every slave, 4'b1110 selects only slave 0 and 4'b1101 selects only slave 1.
- R6: While configuration bit 2 (enable) is clear, no transfer starts, even with bytes queued. Clearing it during a byte stops sclk at its idle level within two cycles, and the partial byte is not queued.
- R7: Queued bytes are sent back to back: 16 sclk edges per byte, all at the same spacing across byte boundaries.
- R8: Both queues hold 8 bytes. Status bit 0 shows transmit empty, bit 1 transmit full, bit 2 receive empty and bit 3 receive full. A write to a full transmit queue is discarded.
- R9: Status bit 4 is set when a byte completes while the receive queue is full. That byte is discarded and the flag stays set until a write to address 2 with bit 4 set.
- R10: Status bit 5 is set while a byte is being shifted. Status bit 0 rises as soon as the last queued byte has been taken, before bit 5 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive queue at address 1) |
| regAddr | input | 2 | Word address: 0 configuration, 1 data, 2 status |
| regWdata | input | 10 | Write data |
| regRdata | output | 10 | Read data for the addressed word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the selected slave |
| csN | output | 4 | Active-low slave selects |

## Verification
The end of one byte and the start of the next fall in the same reference cycle when bytes are queued back to back. In that cycle the receive queue gains a byte, the transmit queue loses one, and the shifter and edge counter restart. The bench queues nine bytes while the block is disabled (the ninth is discarded), then enables it and checks for exactly 128 evenly spaced sclk edges, for what a bench-side slave model captured, and for every returned byte. One more byte arriving at a full receive queue then makes a completion coincide with a full queue, and the bench judges the overflow flag and checks that the queued bytes are intact.

// File: rtl/spi_pkg.sv
package spi_pkg;

  localparam int SEL_W = 4;
  localparam int DIV_W = 3;

  // configuration word, lsb first: polarity, phase, enable, rate code, selects
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             en;
    logic             cpha;
    logic             cpol;
  } spiCfg_t;

  localparam int CFG_W       = $bits(spiCfg_t);
  localparam int CFG_SEL_LSB = 3 + DIV_W;
  localparam int STAT_OVF    = 4;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // take next transmit byte into the shifter
    logic sample;    // capture miso
    logic shiftOut;  // present next bit on mosi
    logic finish;    // byte complete, queue received byte
    logic toggle;    // move sclk
    logic park;      // hold sclk at idle level
  } spiStrobe_t;

endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          doPush, doPop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push & ~full;
  assign doPop   = pop & ~empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEn,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             txEmpty,
  output spiStrobe_t       stb,
  output logic             active
);
  localparam int CNT_W  = (1 << DIV_W) - 1;      // holds the longest half period
  localparam int EDGE_W = $clog2(2 * DATA_W);

  logic [CNT_W-1:0]  divCnt, halfLast;
  logic [EDGE_W-1:0] edgeCnt;
  logic              busy, edgeTick, lastEdge, leading, trailing;

  always_comb begin
    halfLast = (CNT_W'(1) << div) - CNT_W'(1);
    edgeTick = busy & cfgEn & (divCnt == halfLast);
    lastEdge = (edgeCnt == EDGE_W'(2 * DATA_W - 1));
    leading  = edgeTick & ~edgeCnt[0];
    trailing = edgeTick & edgeCnt[0];

    stb.load     = cfgEn & ~txEmpty & (~busy | (trailing & lastEdge));
    stb.sample   = cpha ? trailing : leading;
    stb.shiftOut = cpha ? leading : (trailing & ~lastEdge);
    stb.finish   = trailing & lastEdge;
    stb.toggle   = edgeTick;
    stb.park     = ~busy | ~cfgEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (!cfgEn) begin
      busy <= 1'b0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (stb.finish) begin
      busy <= 1'b0;
    end else if (edgeTick) begin
      divCnt  <= '0;
      edgeCnt <= edgeCnt + 1'b1;
    end else if (busy) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign active = busy;
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [CFG_W-1:0] regWdata,
  output logic [CFG_W-1:0] regRdata,
  input  spiStrobe_t       stb,
  input  logic             active,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output spiCfg_t          cfg,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxOvf
);
  logic              cfgWr, txPush, rxPop, ovfClr;
  logic [DATA_W-1:0] txHead, rxHead, txShift, rxShift, rxNext, rxByte;

  assign cfgWr  = regWrEn & (regAddr == ADDR_CFG);
  assign txPush = regWrEn & (regAddr == ADDR_DATA);
  assign rxPop  = regRdEn & (regAddr == ADDR_DATA);
  assign ovfClr = regWrEn & (regAddr == ADDR_STAT) & regWdata[STAT_OVF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      cfg.sel <= '1;
    end else if (cfgWr) begin
      cfg <= regWdata;
    end
  end

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(regWdata[DATA_W-1:0]),
    .pop(stb.load), .popData(txHead), .full(txFull), .empty(txEmpty)
  );

  // a final sample in the finishing cycle is folded into the queued byte
  assign rxNext = {rxShift[DATA_W-2:0], miso};
  assign rxByte = cfg.cpha ? rxNext : rxShift;

  spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .push(stb.finish), .pushData(rxByte),
    .pop(rxPop), .popData(rxHead), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
      sclk    <= 1'b0;
      rxOvf   <= 1'b0;
    end else begin
      if (stb.load) begin
        // leading-phase sampling needs the first bit out before any edge
        txShift <= cfg.cpha ? txHead : {txHead[DATA_W-2:0], 1'b0};
        if (!cfg.cpha) mosi <= txHead[DATA_W-1];
      end else if (stb.shiftOut) begin
        mosi    <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (stb.sample) rxShift <= rxNext;
      if (stb.park)        sclk <= cfg.cpol;
      else if (stb.toggle) sclk <= ~sclk;
      if (stb.finish && rxFull) rxOvf <= 1'b1;
      else if (ovfClr)          rxOvf <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdata = cfg;
      ADDR_DATA: regRdata = CFG_W'(rxHead);
      ADDR_STAT: regRdata = CFG_W'({active, rxOvf, rxFull, rxEmpty, txFull, txEmpty});
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [CFG_W-1:0] regWdata,
  output logic [CFG_W-1:0] regRdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [SEL_W-1:0] csN
);
  spiStrobe_t stb;
  spiCfg_t    cfg;
  logic       active, txEmpty, txFull, rxEmpty, rxFull, rxOvf;

  spi_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgEn(cfg.en), .cpha(cfg.cpha), .div(cfg.div),
    .txEmpty(txEmpty), .stb(stb), .active(active)
  );

  spi_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .stb(stb), .active(active), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cfg(cfg), .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .rxOvf(rxOvf)
  );

  assign csN = cfg.sel;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk
  import spi_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sclk,
  input logic [SEL_W-1:0] csN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic [SEL_W-1:0] selWrite,
  input logic             clrBit,
  input logic             cpol,
  input logic             en,
  input logic             active,
  input logic             txEmpty,
  input logic             txFull,
  input logic             rxEmpty,
  input logic             rxFull,
  input logic             rxOvf
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!active && $past(!active) && $stable(cpol)) |-> (sclk == cpol));

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!en && $past(!en) && $past(!en, 2) && cpol == $past(cpol) && cpol == $past(cpol, 2))
      |-> $stable(sclk));

  assert_start_needs_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(en && !txEmpty));

  assert_select_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CFG) |=> (csN == $past(selWrite)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvf && !(regWrEn && regAddr == ADDR_STAT && clrBit)) |=> rxOvf);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty) && !(rxFull && rxEmpty));
endmodule

bind spi_master_ctl spi_master_chk i_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .regWrEn(regWrEn),
  .regAddr(regAddr), .selWrite(regWdata[spi_pkg::CFG_SEL_LSB +: spi_pkg::SEL_W]),
  .clrBit(regWdata[spi_pkg::STAT_OVF]), .cpol(cfg.cpol), .en(cfg.en),
  .active(active), .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty),
  .rxFull(rxFull), .rxOvf(rxOvf)
);

// File: tb/test_spi_master_ctl.sv
`timescale 1ns/1ps
module test_spi_master_ctl;
  import spi_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0, miso = 1'b0;
  logic [1:0]       regAddr  = 2'd0;
  logic [CFG_W-1:0] regWdata = '0;
  logic [CFG_W-1:0] regRdata;
  logic             sclk, mosi;
  logic [SEL_W-1:0] csN;

  always #2.5 clk = ~clk;

  spi_master_ctl i_spi_master_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {cpol, cpha, rate code, byte sent, byte the slave returns}
  localparam logic [20:0] VECS [0:5] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 3'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 3'd3, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 3'd7, 8'h96, 8'h69},
    {1'b1, 1'b1, 3'd0, 8'hFF, 8'h01}
  };

  // ---------------- slave model ----------------
  bit         armed = 1'b0, cpolV = 1'b0, cphaV = 1'b0;
  int         edges = 0, minGap = 0, maxGap = 0, dIdx = 0, sBits = 0, capN = 0;
  realtime    lastT = 0.0;
  logic [7:0] curByte = 8'h00, sRx = 8'h00;
  logic [7:0] cap [0:15];

  task automatic slaveDrive();
    if (dIdx == 8) begin
      dIdx = 0;
      curByte = curByte + 8'h11;
    end
    miso = curByte[7 - dIdx];
    dIdx++;
  endtask

  task automatic arm(input bit pol, input bit pha, input logic [7:0] first);
    armed = 1'b0;
    cpolV = pol; cphaV = pha;
    edges = 0; minGap = 1000000; maxGap = 0;
    dIdx = 0; sBits = 0; capN = 0; curByte = first;
    if (!pha) slaveDrive();
    armed = 1'b1;
  endtask

  always @(sclk) begin
    if (armed) begin
      automatic bit lead = (sclk != cpolV);
      if (edges > 0) begin
        automatic int g = int'(($realtime - lastT) / 5.0);
        if (g < minGap) minGap = g;
        if (g > maxGap) maxGap = g;
      end
      edges++;
      lastT = $realtime;
      if (lead != cphaV) begin
        sRx = {sRx[6:0], mosi};
        sBits++;
        if (sBits == 8) begin
          sBits = 0;
          if (capN < 16) cap[capN] = sRx;
          capN++;
        end
      end else begin
        slaveDrive();
      end
    end
  end

  // ---------------- register access ----------------
  task automatic regWrite(input logic [1:0] a, input logic [CFG_W-1:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [CFG_W-1:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [CFG_W-1:0] cfgWord(input bit pol, input bit pha, input bit en,
                                               input logic [2:0] div, input logic [3:0] sel);
    return {sel, div, en, pha, pol};
  endfunction

  task automatic waitIdle(input string req);
    logic [CFG_W-1:0] s;
    for (int i = 0; i < 20000; i++) begin
      regRead(ADDR_STAT, s);
      if (!s[5] && s[0]) return;
    end
    check(1'b0, req, 0, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [CFG_W-1:0] r;
    int e0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(csN == 4'hF, "R1 selects", csN, 4'hF);
    check(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
    regRead(ADDR_STAT, r);
    check(r == 10'h005, "R1 status", r, 10'h005);

    // table of transfers across modes and rates
    for (int v = 0; v < 6; v++) begin
      automatic logic [20:0] e = VECS[v];
      automatic bit pol = e[20], pha = e[19];
      automatic logic [2:0] dv = e[18:16];
      armed = 1'b0;
      regWrite(ADDR_CFG, cfgWord(pol, pha, 1'b0, dv, 4'b1110));
      repeat (3) @(posedge clk);
      arm(pol, pha, e[7:0]);
      regWrite(ADDR_DATA, CFG_W'(e[15:8]));
      regWrite(ADDR_CFG, cfgWord(pol, pha, 1'b1, dv, 4'b1110));
      @(posedge clk);
      regRead(ADDR_STAT, r);
      check(r[5] && r[0], "R10 busy with queue drained", r, 10'h021);
      waitIdle("R10 idle");
      regRead(ADDR_DATA, r);
      check(r[7:0] == e[7:0], "R3 received byte", r, e[7:0]);
      check(capN == 1 && cap[0] == e[15:8], "R3 byte seen by slave", cap[0], e[15:8]);
      check(edges == 16, "R7 edge count", edges, 16);
      check(minGap == (1 << dv) && maxGap == (1 << dv), "R2 half period", maxGap, 1 << dv);
      check(sclk == pol, "R4 idle level", sclk, pol);
      check(csN == 4'b1110, "R5 select held", csN, 4'b1110);
      regWrite(ADDR_CFG, cfgWord(pol, pha, 1'b0, dv, 4'b1110));
    end
    armed = 1'b0;

    // R5 selects follow the field
    regWrite(ADDR_CFG, cfgWord(1'b0, 1'b0, 1'b0, 3'd0, 4'b1101));
    check(csN == 4'b1101, "R5 select 1", csN, 4'b1101);
    regWrite(ADDR_CFG, cfgWord(1'b0, 1'b0, 1'b0, 3'd0, 4'b1111));
    check(csN == 4'b1111, "R5 none selected", csN, 4'b1111);

    // R6 nothing moves while disabled
    repeat (3) @(posedge clk);
    arm(1'b0, 1'b0, 8'hE7);
    regWrite(ADDR_DATA, 10'h042);
    repeat (50) @(posedge clk);
    check(edges == 0, "R6 no edges while disabled", edges, 0);
    regRead(ADDR_STAT, r);
    check(r[0] == 1'b0, "R6 byte still queued", r[0], 0);
    regWrite(ADDR_CFG, cfgWord(1'b0, 1'b0, 1'b1, 3'd0, 4'b1111));
    waitIdle("R6 idle after enable");
    check(cap[0] == 8'h42, "R6 queued byte sent on enable", cap[0], 8'h42);
    regRead(ADDR_DATA, r);
    check(r[7:0] == 8'hE7, "R6 byte received on enable", r[7:0], 8'hE7);

    // R6 abort in the middle of a byte
    armed = 1'b0;
    regWrite(ADDR_CFG, cfgWord(1'b1, 1'b1, 1'b0, 3'd3, 4'b1110));
    repeat (3) @(posedge clk);
    arm(1'b1, 1'b1, 8'h5C);
    regWrite(ADDR_DATA, 10'h033);
    regWrite(ADDR_CFG, cfgWord(1'b1, 1'b1, 1'b1, 3'd3, 4'b1110));
    repeat (40) @(posedge clk);
    regWrite(ADDR_CFG, cfgWord(1'b1, 1'b1, 1'b0, 3'd3, 4'b1110));
    repeat (2) @(posedge clk);
    check(sclk == 1'b1, "R6 sclk parked after abort", sclk, 1);
    regRead(ADDR_STAT, r);
    check(r[5] == 1'b0 && r[2] == 1'b1, "R6 stopped, partial byte dropped", r, 10'h005);
    e0 = edges;
    repeat (200) @(posedge clk);
    check(edges == e0, "R6 no further edges", edges, e0);

    // R7/R8/R9 queue limits, back-to-back bytes, overflow
    armed = 1'b0;
    regWrite(ADDR_CFG, cfgWord(1'b0, 1'b0, 1'b0, 3'd0, 4'b1110));
    repeat (3) @(posedge clk);
    arm(1'b0, 1'b0, 8'hA0);
    for (int i = 0; i < 9; i++) regWrite(ADDR_DATA, CFG_W'(8'h30 + i));
    regRead(ADDR_STAT, r);
    check(r[1] == 1'b1, "R8 transmit full", r[1], 1);
    regWrite(ADDR_CFG, cfgWord(1'b0, 1'b0, 1'b1, 3'd0, 4'b1110));
    waitIdle("R7 idle after burst");
    check(edges == 128, "R8 ninth byte dropped, 8 bytes sent", edges, 128);
    check(minGap == 1 && maxGap == 1, "R7 no gap between bytes", maxGap, 1);
    regRead(ADDR_STAT, r);
    check(r[3] == 1'b1 && r[4] == 1'b0, "R8 receive full, no overflow", r, 10'h009);
    regWrite(ADDR_DATA, 10'h055);
    waitIdle("R9 idle after extra byte");
    regRead(ADDR_STAT, r);
    check(r[4] == 1'b1, "R9 overflow set", r[4], 1);
    for (int k = 0; k < 8; k++)
      check(cap[k] == 8'(8'h30 + k), "R8 slave capture order", cap[k], 8'h30 + k);
    check(capN == 9 && cap[8] == 8'h55, "R8 next byte after dropped one", cap[8], 8'h55);
    for (int k = 0; k < 8; k++) begin
      regRead(ADDR_DATA, r);
      check(r[7:0] == 8'(8'hA0 + 8'h11 * k), "R9 queued bytes intact", r[7:0], 8'hA0 + 8'h11 * k);
    end
    regRead(ADDR_STAT, r);
    check(r[2] == 1'b1 && r[4] == 1'b1, "R9 overflow sticky after drain", r, 10'h015);
    regWrite(ADDR_STAT, 10'h010);
    regRead(ADDR_STAT, r);
    check(r[4] == 1'b0, "R9 overflow cleared", r[4], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule